// File: doc/BRIEF.md
# Permission-Checking Address Translation Cache

This block is a small, fully associative cache of page translations. Each lookup presents a virtual address, a write flag, the requester's privilege level and a valid strobe. In the same cycle the block compares the virtual page number against every stored entry and, on a match, applies the entry's permission bits.

The result is a physical address, formed from the stored frame number and the untouched 12-bit page offset. Alongside it come hit, miss and protection-fault indications.

A miss is resolved outside the block: an external table walker fetches the translation and installs it through the fill port. The fill goes to a free slot if one exists. Otherwise it replaces the least recently used entry, or it overwrites an existing entry that holds the same page. The first write to a clean page marks the entry dirty and raises a one-cycle strobe, so that the in-memory table copy can be updated. A flush input empties the whole cache in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid; every lookup reports a miss and `physAddr` is zero.
- R2: A lookup that matches a present entry, with permissions satisfied, asserts `hit` in the same cycle (combinationally). `physAddr` is then `{frame, lkAddr[11:0]}`, and `miss` and `protFault` stay low.
- R3: A lookup whose page matches no valid entry, or matches an entry with the present bit clear, asserts `miss` with `hit` low and `physAddr` zero.
- R4: A write lookup that hits a present entry whose writable bit is clear asserts `protFault`, with `hit` and `miss` low. A read of the same entry hits.
- R5: A lookup at privilege level other than 0 (user) to a present entry whose user-access bit is clear asserts `protFault`. At level 0 (supervisor) the user-access bit has no effect.
- R6: A write hit on an entry whose dirty bit is clear pulses `dirtyUpd` in that cycle and sets the dirty bit. Later write hits to that entry, read hits, and writes to entries installed dirty do not pulse `dirtyUpd`.
- R7: Fills into a cache with free slots never evict. All `ENTRIES` (default 32) distinct pages filled after a flush remain resident and translate to their own frames.
- R8: When the cache is full, a fill of a new page evicts the entry least recently hit or filled. A hitting lookup counts as a use; a miss does not.
- R9: A fill whose page already resides in the cache overwrites that entry in place. No duplicate is created and no other entry is evicted.
- R10: `flush` invalidates every entry at the next clock edge. A lookup in the flush cycle reports a miss. A fill in the flush cycle is discarded.
- R11: While `lkValid` is low, `hit`, `miss`, `protFault` and `dirtyUpd` are low and `physAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request valid |
| lkAddr | input | VA_W | Virtual address to translate |
| lkWrite | input | 1 | Lookup is a write access |
| lkPriv | input | PRIV_W | Privilege level; 0 is supervisor, higher is less privileged |
| flush | input | 1 | Invalidate all entries |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | VA_W-PAGE_BITS | Virtual page number of the fill |
| fillPfn | input | PA_W-PAGE_BITS | Frame number of the fill |
| fillPresent | input | 1 | Page is resident in memory |
| fillWritable | input | 1 | Page may be written |
| fillUserOk | input | 1 | Page may be accessed at non-zero privilege |
| fillDirty | input | 1 | Page is already marked written |
| physAddr | output | PA_W | Translated address, zero when not hit |
| hit | output | 1 | Translation found and permitted |
| miss | output | 1 | Translation must be fetched |
| protFault | output | 1 | Translation found but access forbidden |
| dirtyUpd | output | 1 | First write to a clean page |

## Verification
The bench targets eviction order after a full cache has been re-touched. A design that aged entries on misses, or that picked the oldest fill instead of the oldest use, would drop a page that is still in use and keep a stale one. It fills a page that is already resident. A design without the in-place overwrite would hold two matching entries and return a merged, wrong frame. It issues a lookup and a fill in the flush cycle. Getting that wrong shows up as a stale hit, or as a page that survives the flush. Finally, it repeats writes to the same clean page and checks that the dirty strobe fires exactly once. It also checks that supervisor accesses ignore the user-access bit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // index width covers the largest supported cache (128 entries)
  localparam int IDX_W = 7;

  typedef struct packed {
    logic present;
    logic writable;
    logic userOk;
    logic dirty;
  } perm_t;

  // strobes from control to the entry store
  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             dirtyEn;
    logic [IDX_W-1:0] dirtyIdx;
    logic             flushAll;
  } strb_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  strb_t              strb,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  perm_t              fillPerm,
  output logic [ENTRIES-1:0] matchVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [ENTRIES-1:0] validVec,
  output perm_t              selPerm,
  output logic [PFN_W-1:0]   selPfn
);

  logic             validQ [ENTRIES];
  logic [VPN_W-1:0] vpnQ   [ENTRIES];
  logic [PFN_W-1:0] pfnQ   [ENTRIES];
  perm_t            permQ  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i] <= 1'b0;
        vpnQ[i]   <= '0;
        pfnQ[i]   <= '0;
        permQ[i]  <= '0;
      end
    end else if (strb.flushAll) begin
      for (int i = 0; i < ENTRIES; i++) validQ[i] <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.dirtyEn && strb.dirtyIdx == IDX_W'(i))
          permQ[i].dirty <= 1'b1;
        // a fill to the same slot takes precedence
        if (strb.fillEn && strb.fillIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          vpnQ[i]   <= fillVpn;
          pfnQ[i]   <= fillPfn;
          permQ[i]  <= fillPerm;
        end
      end
    end
  end

  always_comb begin
    selPerm = '0;
    selPfn  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      validVec[i]   = validQ[i];
      matchVec[i]   = validQ[i] && (vpnQ[i] == lkVpn);
      fillHitVec[i] = validQ[i] && (vpnQ[i] == fillVpn);
      if (matchVec[i]) begin
        selPerm = selPerm | permQ[i];
        selPfn  = selPfn | pfnQ[i];
      end
    end
  end

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validVec == '0));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R7
    fill_installs_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.fillEn && !strb.flushAll && strb.fillIdx == IDX_W'(g))
      |=> (validQ[g] && vpnQ[g] == $past(fillVpn)));
    // R6
    dirty_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.dirtyEn && !strb.flushAll && strb.dirtyIdx == IDX_W'(g) &&
       !(strb.fillEn && strb.fillIdx == IDX_W'(g)))
      |=> permQ[g].dirty);
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               lkWrite,
  input  logic               lkUser,
  input  logic               flush,
  input  logic               fillValid,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [ENTRIES-1:0] validVec,
  input  perm_t              selPerm,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output logic               dirtyUpd,
  output strb_t              strb
);

  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(ENTRIES - 1);

  logic [AGE_W-1:0] ageQ [ENTRIES];

  logic             present, denied, freeFound, fillHit;
  logic [IDX_W-1:0] hitIdx, fillHitIdx, freeIdx, oldIdx, victimIdx, touchIdx;
  logic [AGE_W-1:0] hitAge, victimAge, touchAge;
  logic             touchEn;

  always_comb begin
    present   = lkValid && (|matchVec) && selPerm.present;
    denied    = (lkWrite && !selPerm.writable) || (lkUser && !selPerm.userOk);
    hit       = present && !flush && !denied;
    protFault = present && !flush && denied;
    miss      = lkValid && (flush || !present);
    dirtyUpd  = hit && lkWrite && !selPerm.dirty;
  end

  // priority encoders: lowest index wins
  always_comb begin
    hitIdx     = '0;
    fillHitIdx = '0;
    freeIdx    = '0;
    oldIdx     = '0;
    freeFound  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])   hitIdx     = IDX_W'(i);
      if (fillHitVec[i]) fillHitIdx = IDX_W'(i);
      if (ageQ[i] == MAX_AGE) oldIdx = IDX_W'(i);
      if (!validVec[i]) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
    fillHit   = |fillHitVec;
    victimIdx = fillHit ? fillHitIdx : (freeFound ? freeIdx : oldIdx);
  end

  // free slots always carry MAX_AGE, so the victim's own age is the touch age
  always_comb begin
    hitAge    = '0;
    victimAge = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IDX_W'(i) == hitIdx)    hitAge    = ageQ[i];
      if (IDX_W'(i) == victimIdx) victimAge = ageQ[i];
    end
    strb.fillEn   = fillValid && !flush;
    strb.fillIdx  = victimIdx;
    strb.dirtyEn  = dirtyUpd;
    strb.dirtyIdx = hitIdx;
    strb.flushAll = flush;
    touchEn  = strb.fillEn || hit;
    touchIdx = strb.fillEn ? victimIdx : hitIdx;
    touchAge = strb.fillEn ? victimAge : hitAge;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= MAX_AGE;
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx)   ageQ[i] <= '0;
        else if (ageQ[i] < touchAge) ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end

  // R9
  unique_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PRIV_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lkValid,
  input  logic [VA_W-1:0]           lkAddr,
  input  logic                      lkWrite,
  input  logic [PRIV_W-1:0]         lkPriv,
  input  logic                      flush,
  input  logic                      fillValid,
  input  logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] fillPfn,
  input  logic                      fillPresent,
  input  logic                      fillWritable,
  input  logic                      fillUserOk,
  input  logic                      fillDirty,
  output logic [PA_W-1:0]           physAddr,
  output logic                      hit,
  output logic                      miss,
  output logic                      protFault,
  output logic                      dirtyUpd
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;

  strb_t              strb;
  perm_t              fillPerm, selPerm;
  logic [ENTRIES-1:0] matchVec, fillHitVec, validVec;
  logic [PFN_W-1:0]   selPfn;
  logic               lkUser;

  assign lkUser   = (lkPriv != '0);
  assign fillPerm = '{present: fillPresent, writable: fillWritable,
                      userOk: fillUserOk, dirty: fillDirty};

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lkVpn(lkAddr[VA_W-1:PAGE_BITS]), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillPerm(fillPerm), .matchVec(matchVec), .fillHitVec(fillHitVec),
    .validVec(validVec), .selPerm(selPerm), .selPfn(selPfn)
  );

  xlat_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .lkUser(lkUser), .flush(flush), .fillValid(fillValid),
    .matchVec(matchVec), .fillHitVec(fillHitVec), .validVec(validVec),
    .selPerm(selPerm), .hit(hit), .miss(miss), .protFault(protFault),
    .dirtyUpd(dirtyUpd), .strb(strb)
  );

  assign physAddr = hit ? {selPfn, lkAddr[PAGE_BITS-1:0]} : '0;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!hit && !miss && !protFault && !dirtyUpd && physAddr == '0));

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkWrite = 0, flush = 0, fillValid = 0;
  logic [31:0] lkAddr = '0;
  logic [1:0]  lkPriv = '0;
  logic [19:0] fillVpn = '0, fillPfn = '0;
  logic        fillPresent = 0, fillWritable = 0, fillUserOk = 0, fillDirty = 0;
  logic [31:0] physAddr;
  logic        hit, miss, protFault, dirtyUpd;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr),
    .lkWrite(lkWrite), .lkPriv(lkPriv), .flush(flush), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillPresent(fillPresent),
    .fillWritable(fillWritable), .fillUserOk(fillUserOk), .fillDirty(fillDirty),
    .physAddr(physAddr), .hit(hit), .miss(miss), .protFault(protFault),
    .dirtyUpd(dirtyUpd)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outputs packed as {hit, miss, fault, dirty}
  function automatic logic [3:0] flags();
    return {hit, miss, protFault, dirtyUpd};
  endfunction

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic p, input logic w, input logic u, input logic d);
    @(negedge clk);
    fillValid = 1; fillVpn = vpn; fillPfn = pfn;
    fillPresent = p; fillWritable = w; fillUserOk = u; fillDirty = d;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic [1:0] pl,
                      output logic [3:0] f, output logic [31:0] pa);
    @(negedge clk);
    lkValid = 1; lkAddr = va; lkWrite = w; lkPriv = pl;
    #1;
    f = flags(); pa = physAddr;
    @(negedge clk);
    lkValid = 0; lkWrite = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic t_reset();
    logic [3:0] f; logic [31:0] pa;
    #1;
    check("R11 idle flags", {60'd0, flags()}, 64'd0);
    look(32'h0000_1000, 0, 0, f, pa);
    check("R1 miss after reset", {60'd0, f}, 64'b0100);
    check("R1 addr zero", {32'd0, pa}, 64'd0);
  endtask

  task automatic t_basic();
    logic [3:0] f; logic [31:0] pa;
    fill(20'h12345, 20'hABCDE, 1, 1, 1, 1);
    look(32'h1234_5678, 0, 3, f, pa);
    check("R2 hit flags", {60'd0, f}, 64'b1000);
    check("R2 phys addr", {32'd0, pa}, {32'd0, 32'hABCD_E678});
    look(32'h5432_1FFF, 0, 0, f, pa);
    check("R3 unknown page miss", {60'd0, f}, 64'b0100);
    check("R3 miss addr zero", {32'd0, pa}, 64'd0);
    @(negedge clk);
    lkValid = 0; lkAddr = 32'h1234_5000; #1;
    check("R11 idle with matching addr", {28'd0, flags(), physAddr}, 64'd0);
  endtask

  task automatic t_present();
    logic [3:0] f; logic [31:0] pa;
    fill(20'h00002, 20'h0AAAA, 0, 1, 1, 0);
    look(32'h0000_2010, 0, 0, f, pa);
    check("R3 not-present miss", {60'd0, f}, 64'b0100);
    check("R3 not-present addr", {32'd0, pa}, 64'd0);
  endtask

  task automatic t_perm();
    logic [3:0] f; logic [31:0] pa;
    fill(20'h00003, 20'h00033, 1, 0, 1, 0);
    look(32'h0000_3004, 1, 3, f, pa);
    check("R4 write to read-only faults", {60'd0, f}, 64'b0010);
    look(32'h0000_3004, 0, 3, f, pa);
    check("R4 read of read-only hits", {28'd0, f, pa}, {28'd0, 4'b1000, 32'h0003_3004});
    fill(20'h00004, 20'h00044, 1, 1, 0, 1);
    look(32'h0000_4100, 0, 3, f, pa);
    check("R5 user read of kernel page faults", {60'd0, f}, 64'b0010);
    look(32'h0000_4100, 1, 1, f, pa);
    check("R5 level1 write kernel page faults", {60'd0, f}, 64'b0010);
    look(32'h0000_4100, 1, 0, f, pa);
    check("R5 supervisor ignores user bit", {28'd0, f, pa}, {28'd0, 4'b1000, 32'h0004_4100});
  endtask

  task automatic t_dirty();
    logic [3:0] f; logic [31:0] pa;
    fill(20'h00005, 20'h00055, 1, 1, 1, 0);
    look(32'h0000_5000, 0, 2, f, pa);
    check("R6 read no strobe", {60'd0, f}, 64'b1000);
    look(32'h0000_5000, 1, 2, f, pa);
    check("R6 first write strobe", {60'd0, f}, 64'b1001);
    look(32'h0000_5008, 1, 2, f, pa);
    check("R6 second write no strobe", {60'd0, f}, 64'b1000);
    fill(20'h00006, 20'h00066, 1, 1, 1, 1);
    look(32'h0000_6000, 1, 0, f, pa);
    check("R6 installed-dirty no strobe", {60'd0, f}, 64'b1000);
  endtask

  task automatic t_flush();
    logic [3:0] f; logic [31:0] pa;
    @(negedge clk);
    flush = 1; lkValid = 1; lkAddr = 32'h0000_5000; lkWrite = 0; lkPriv = 0;
    fillValid = 1; fillVpn = 20'h00007; fillPfn = 20'h00077;
    fillPresent = 1; fillWritable = 1; fillUserOk = 1; fillDirty = 0;
    #1;
    check("R10 lookup in flush cycle misses", {28'd0, flags(), physAddr}, {28'd0, 4'b0100, 32'd0});
    @(negedge clk);
    flush = 0; lkValid = 0; fillValid = 0;
    look(32'h0000_5000, 0, 0, f, pa);
    check("R10 entry gone after flush", {60'd0, f}, 64'b0100);
    look(32'h0000_7000, 0, 0, f, pa);
    check("R10 fill in flush cycle dropped", {60'd0, f}, 64'b0100);
  endtask

  task automatic t_capacity();
    logic [3:0] f; logic [31:0] pa;
    int bad = 0;
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 1);
    for (int i = 0; i < N; i++) begin
      look({20'h00100 + 20'(i), 12'h0AB}, 0, 0, f, pa);
      if (f != 4'b1000 || pa != {20'h00200 + 20'(i), 12'h0AB}) bad++;
    end
    check("R7 all entries resident", 64'(bad), 64'd0);
  endtask

  task automatic t_lru();
    logic [3:0] f; logic [31:0] pa;
    look(32'h0010_0000, 0, 0, f, pa);
    check("R8 touch oldest", {60'd0, f}, 64'b1000);
    fill(20'h00300, 20'h00999, 1, 1, 1, 1);
    look(32'h0010_1000, 0, 0, f, pa);
    check("R8 least recently used evicted", {60'd0, f}, 64'b0100);
    look(32'h0030_0123, 0, 0, f, pa);
    check("R8 new page resident", {28'd0, f, pa}, {28'd0, 4'b1000, 32'h0099_9123});
    look(32'h0010_0000, 0, 0, f, pa);
    check("R8 touched page kept", {60'd0, f}, 64'b1000);
    look(32'h0010_2000, 0, 0, f, pa);
    check("R8 next-oldest kept", {60'd0, f}, 64'b1000);
  endtask

  task automatic t_refill();
    logic [3:0] f; logic [31:0] pa;
    int bad = 0;
    fill(20'h00102, 20'h00777, 1, 1, 1, 1);
    look(32'h0010_2FFF, 0, 0, f, pa);
    check("R9 overwritten in place", {28'd0, f, pa}, {28'd0, 4'b1000, 32'h0077_7FFF});
    for (int i = 3; i < N; i++) begin
      look({20'h00100 + 20'(i), 12'h000}, 0, 0, f, pa);
      if (f != 4'b1000) bad++;
    end
    check("R9 no other entry evicted", 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_basic();
    t_present();
    t_perm();
    t_dirty();
    t_flush();
    do_flush();
    t_capacity();
    t_lru();
    t_refill();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule